// File: doc/BRIEF.md
# I2C Master Interrupt and Abort Status Collector

This block sits beside an I2C master engine and turns its one-cycle event pulses into sticky status. Underflow and overflow of the receive queue, overflow of the transmit queue, a transfer abort, and bus START and STOP detection are each latched into a raw status word. Two more bits of that word follow the queue fill levels against their thresholds. A mask selects which raw bits drive a single interrupt line.

When the engine aborts a transfer, it also presents a cause vector. The block ORs that vector into an abort source word and raises a hold that keeps the transmit queue in flush. Software reads dedicated addresses to clear single error bits, and one combined address to clear every latched bit. Only a read of the abort-clear address zeroes the source word and releases the flush hold. A transfer counts as busy while START is latched and STOP is not.

Top module: `i2c_irq_status`

## Requirements
- R1: Each event input pulse sets its latched raw bit on the next clock edge, and the bit stays set until a clear read. Raw bit positions: 0 RX underflow, 1 RX overflow, 2 TX overflow, 3 abort, 4 START seen, 5 STOP seen.
- R2: A read of address 5, 6, 7 or 8 clears only raw bit 0, 1, 2 or 3 respectively.
- R3: A read of address 4 clears raw bits 0 to 5. It leaves the mask, the abort source word and the flush hold unchanged.
- R4: An event pulse that arrives in the same cycle as a read that would clear its bit wins, so the bit stays set.
- R5: A write to address 2 loads the mask from wr_data. The masked status equals raw AND mask. irq is high exactly when the masked status is nonzero. The raw status does not depend on the mask.
- R6: Raw bit 6 is 1 when tx_level <= tx_thresh. Raw bit 7 is 1 when rx_level > rx_thresh. Both follow the levels combinationally and no read clears them.
- R7: On abort_pulse, abort_cause is ORed into abort_src on the next edge. Source bit positions: 0 user abort, 1 arbitration lost, 2 no ack to 7-bit address, 3 no ack to first 10-bit address byte, 4 no ack to second 10-bit address byte, 5 no ack on data, 6 no ack to general call, 7 general call with read, 8 restart while restarts are disabled, 9 START byte acknowledged. A read of address 8 zeroes the word; a cause arriving in the same cycle is kept.
- R8: tx_flush_hold rises on the edge after abort_pulse. It falls only on the edge after a read of address 8 that has no abort_pulse in the same cycle.
- R9: rd_data is combinational from addr: 0 and 4 to 8 give the raw status, 1 the masked status, 2 the mask, 3 the abort source word, and any other address gives 0.
- R10: xfer_busy is high when raw bit 4 is set and raw bit 5 is clear.
- R11: After reset, the latched bits, the mask, the abort source word and the flush hold are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_rx_under | input | 1 | RX underflow pulse |
| ev_rx_over | input | 1 | RX overflow pulse |
| ev_tx_over | input | 1 | TX overflow pulse |
| ev_start | input | 1 | START detected pulse |
| ev_stop | input | 1 | STOP detected pulse |
| abort_pulse | input | 1 | Transfer aborted pulse |
| abort_cause | input | ABT_W | Cause bits valid with abort_pulse |
| tx_level | input | LVL_W | TX queue fill |
| tx_thresh | input | LVL_W | TX threshold |
| rx_level | input | LVL_W | RX queue fill |
| rx_thresh | input | LVL_W | RX threshold |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Register address |
| wr_data | input | NSTAT | Write data (mask) |
| rd_data | output | DW | Read data |
| raw_stat | output | NSTAT | Raw status |
| masked_stat | output | NSTAT | Raw status AND mask |
| abort_src | output | ABT_W | Accumulated abort causes |
| irq | output | 1 | Interrupt line |
| tx_flush_hold | output | 1 | Keeps the TX queue in flush |
| xfer_busy | output | 1 | Transfer in progress |

## Verification
The stimulus first drives isolated pulses on each event input. This separates the bit positions and shows that bits stay latched. It then issues each clear address on its own, which shows whether a clear reaches any bit other than its own. Pulses are placed in the same cycle as their clears to distinguish event-wins priority from clear-wins priority. Abort pulses with different cause vectors show OR accumulation, and a clear-all before the abort clear shows that the flush hold depends only on the dedicated address. Level and threshold sweeps around equality locate the comparison boundaries, and mask changes with fixed raw status separate the masked path from the raw path.

// File: rtl/i2c_irq_status.sv
module i2c_irq_status #(
  parameter int LVL_W = 5,
  parameter int ABT_W = 10,
  parameter int AW    = 4,
  parameter int DW    = 32,
  parameter int NSTAT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_rx_under,
  input  logic             ev_rx_over,
  input  logic             ev_tx_over,
  input  logic             ev_start,
  input  logic             ev_stop,
  input  logic             abort_pulse,
  input  logic [ABT_W-1:0] abort_cause,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] tx_thresh,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] rx_thresh,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [NSTAT-1:0] wr_data,
  output logic [DW-1:0]    rd_data,
  output logic [NSTAT-1:0] raw_stat,
  output logic [NSTAT-1:0] masked_stat,
  output logic [ABT_W-1:0] abort_src,
  output logic             irq,
  output logic             tx_flush_hold,
  output logic             xfer_busy
);
  localparam int NLAT = 6;
  localparam logic [AW-1:0] A_RAW = AW'(0), A_MSK = AW'(1), A_MASK = AW'(2),
                            A_SRC = AW'(3), A_CALL = AW'(4), A_CRXU = AW'(5),
                            A_CRXO = AW'(6), A_CTXO = AW'(7), A_CABT = AW'(8);

  logic [NLAT-1:0]  lat_q;
  logic [NLAT-1:0]  set_v, clr_v;
  logic [NSTAT-1:0] mask_q;
  logic             clr_all, clr_abt;

  assign clr_all = rd_en && addr == A_CALL;
  assign clr_abt = rd_en && addr == A_CABT;

  assign set_v = {ev_stop, ev_start, abort_pulse, ev_tx_over, ev_rx_over, ev_rx_under};
  assign clr_v = {clr_all, clr_all, clr_all || clr_abt,
                  clr_all || (rd_en && addr == A_CTXO),
                  clr_all || (rd_en && addr == A_CRXO),
                  clr_all || (rd_en && addr == A_CRXU)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q         <= '0;
      mask_q        <= '0;
      abort_src     <= '0;
      tx_flush_hold <= 1'b0;
    end else begin
      lat_q <= (lat_q & ~clr_v) | set_v;
      if (wr_en && addr == A_MASK) mask_q <= wr_data;
      abort_src <= (clr_abt ? '0 : abort_src) | (abort_pulse ? abort_cause : '0);
      if (abort_pulse)  tx_flush_hold <= 1'b1;
      else if (clr_abt) tx_flush_hold <= 1'b0;
    end
  end

  assign raw_stat    = {rx_level > rx_thresh, tx_level <= tx_thresh, lat_q};
  assign masked_stat = raw_stat & mask_q;
  assign irq         = |masked_stat;
  assign xfer_busy   = lat_q[4] & ~lat_q[5];

  always_comb begin
    rd_data = '0;
    case (addr)
      A_RAW, A_CALL, A_CRXU, A_CRXO, A_CTXO, A_CABT: rd_data[NSTAT-1:0] = raw_stat;
      A_MSK:  rd_data[NSTAT-1:0] = masked_stat;
      A_MASK: rd_data[NSTAT-1:0] = mask_q;
      A_SRC:  rd_data[ABT_W-1:0] = abort_src;
      default: rd_data = '0;
    endcase
  end
endmodule

module i2c_irq_status_chk #(
  parameter int ABT_W = 10,
  parameter int AW    = 4,
  parameter int NSTAT = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_en,
  input logic [AW-1:0]    addr,
  input logic             ev_rx_under,
  input logic             ev_rx_over,
  input logic             abort_pulse,
  input logic [NSTAT-1:0] raw_stat,
  input logic [NSTAT-1:0] mask_q,
  input logic             irq,
  input logic [ABT_W-1:0] abort_src,
  input logic             tx_flush_hold,
  input logic             xfer_busy
);
  assert_event_latch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_over |=> raw_stat[1]);
  assert_single_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == AW'(5) && !ev_rx_under) |=> !raw_stat[0]);
  assert_irq_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq == ((raw_stat & mask_q) != '0));
  assert_src_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == AW'(8) && !abort_pulse) |=> abort_src == '0);
  assert_hold_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |=> tx_flush_hold);
  assert_hold_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_flush_hold) |-> $past(rd_en && addr == AW'(8)));
  assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_busy |-> (raw_stat[4] && !raw_stat[5]));
endmodule

bind i2c_irq_status i2c_irq_status_chk #(.ABT_W(ABT_W), .AW(AW), .NSTAT(NSTAT)) chk_i (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr),
  .ev_rx_under(ev_rx_under), .ev_rx_over(ev_rx_over), .abort_pulse(abort_pulse),
  .raw_stat(raw_stat), .mask_q(mask_q), .irq(irq), .abort_src(abort_src),
  .tx_flush_hold(tx_flush_hold), .xfer_busy(xfer_busy));

// File: tb/i2c_irq_status_tb.sv
`timescale 1ns/1ps
module i2c_irq_status_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_rx_under = 0, ev_rx_over = 0, ev_tx_over = 0, ev_start = 0, ev_stop = 0;
  logic abort_pulse = 0;
  logic [9:0] abort_cause = '0;
  logic [4:0] tx_level = 5'd3, tx_thresh = 5'd1, rx_level = 5'd0, rx_thresh = 5'd0;
  logic rd_en = 0, wr_en = 0;
  logic [3:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [7:0] raw_stat, masked_stat;
  logic [9:0] abort_src;
  logic irq, tx_flush_hold, xfer_busy;

  int total = 0, bad = 0;
  bit done = 0;

  // model state
  bit m_rxu, m_rxo, m_txo, m_abt, m_sta, m_sto, m_hold;
  bit [7:0] m_mask;
  bit [9:0] m_src;

  always #2.5 clk = ~clk;

  i2c_irq_status dut_i (
    .clk(clk), .rst_n(rst_n), .ev_rx_under(ev_rx_under), .ev_rx_over(ev_rx_over),
    .ev_tx_over(ev_tx_over), .ev_start(ev_start), .ev_stop(ev_stop),
    .abort_pulse(abort_pulse), .abort_cause(abort_cause),
    .tx_level(tx_level), .tx_thresh(tx_thresh), .rx_level(rx_level), .rx_thresh(rx_thresh),
    .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
    .raw_stat(raw_stat), .masked_stat(masked_stat), .abort_src(abort_src), .irq(irq),
    .tx_flush_hold(tx_flush_hold), .xfer_busy(xfer_busy));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      {m_rxu, m_rxo, m_txo, m_abt, m_sta, m_sto, m_hold} = '0;
      m_mask = '0; m_src = '0;
    end else begin
      if (rd_en && (addr == 4 || addr == 5)) m_rxu = 0;
      if (rd_en && (addr == 4 || addr == 6)) m_rxo = 0;
      if (rd_en && (addr == 4 || addr == 7)) m_txo = 0;
      if (rd_en && (addr == 4 || addr == 8)) m_abt = 0;
      if (rd_en && addr == 4) begin m_sta = 0; m_sto = 0; end
      if (rd_en && addr == 8) begin m_src = '0; m_hold = 0; end
      if (ev_rx_under) m_rxu = 1;
      if (ev_rx_over)  m_rxo = 1;
      if (ev_tx_over)  m_txo = 1;
      if (ev_start)    m_sta = 1;
      if (ev_stop)     m_sto = 1;
      if (abort_pulse) begin m_abt = 1; m_hold = 1; m_src = m_src | abort_cause; end
      if (wr_en && addr == 2) m_mask = wr_data;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit [7:0] e_raw, e_msk;
      bit [31:0] e_rd;
      e_raw = {rx_level > rx_thresh, tx_level <= tx_thresh, m_sto, m_sta, m_abt, m_txo, m_rxo, m_rxu};
      e_msk = e_raw & m_mask;
      case (addr)
        0, 4, 5, 6, 7, 8: e_rd = {24'd0, e_raw};
        1: e_rd = {24'd0, e_msk};
        2: e_rd = {24'd0, m_mask};
        3: e_rd = {22'd0, m_src};
        default: e_rd = 0;
      endcase
      chk("R1,R2,R3,R4 latched bits", {26'd0, raw_stat[5:0]}, {26'd0, e_raw[5:0]});
      chk("R6 level bits", {30'd0, raw_stat[7:6]}, {30'd0, e_raw[7:6]});
      chk("R5 masked", {24'd0, masked_stat}, {24'd0, e_msk});
      chk("R5 irq", {31'd0, irq}, {31'd0, e_msk != 0});
      chk("R7 abort source", {22'd0, abort_src}, {22'd0, m_src});
      chk("R8 flush hold", {31'd0, tx_flush_hold}, {31'd0, m_hold});
      chk("R9 read data", rd_data, e_rd);
      chk("R10 busy", {31'd0, xfer_busy}, {31'd0, m_sta && !m_sto});
    end
  end

  task automatic step();
    @(posedge clk); #1;
    {ev_rx_under, ev_rx_over, ev_tx_over, ev_start, ev_stop, abort_pulse} = '0;
    abort_cause = '0; rd_en = 0; wr_en = 0;
  endtask

  task automatic rd(input int a);
    addr = 4'(a); rd_en = 1; step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 reset raw", {24'd0, raw_stat}, 32'd0);
    chk("R11 reset src/hold", {21'd0, abort_src, tx_flush_hold}, 32'd0);
    @(posedge clk); #1 rst_n = 1;
    step();
    // R1 isolated pulses
    ev_rx_under = 1; step();
    ev_rx_over = 1; step();
    ev_tx_over = 1; step();
    ev_start = 1; step(); step();
    addr = 0; step();
    // R5 mask
    addr = 2; wr_en = 1; wr_data = 8'h05; step();
    addr = 1; step();
    addr = 2; step();
    // R2 individual clears
    rd(5); rd(7); addr = 0; step();
    // R4 collision
    addr = 6; rd_en = 1; ev_rx_over = 1; step();
    rd(6);
    addr = 5; rd_en = 1; ev_rx_under = 1; step();
    // R10 stop
    ev_stop = 1; step();
    // R6 levels
    tx_level = 1; step(); tx_level = 0; step(); tx_level = 2; step();
    rx_level = 1; step(); rx_thresh = 1; step(); rx_thresh = 0; rd(4); step();
    // R7/R8 aborts
    abort_pulse = 1; abort_cause = 10'h002; step();
    abort_pulse = 1; abort_cause = 10'h200; step();
    addr = 3; step();
    rd(4); addr = 3; step(); step();
    rd(7); step();
    addr = 8; rd_en = 1; abort_pulse = 1; abort_cause = 10'h010; step();
    addr = 3; step();
    rd(8); addr = 3; step();
    abort_pulse = 1; abort_cause = 10'h081; step();
    addr = 2; wr_en = 1; wr_data = 8'h08; step();
    rd(8); step();
    rd(12); ev_start = 1; step(); step();
    addr = 2; wr_en = 1; wr_data = 8'hFF; step(); step();
    repeat (3) step();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog timeout");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule